// File: doc/BRIEF.md
# Paged EEPROM Write Controller

This controller sits on the host side of a byte-wide parallel EEPROM and writes a buffer into it. A transfer starts with a start pulse that carries a first address and a byte count. The bytes then arrive over a valid/ready stream. The controller drives the active-low chip-select, write and read strobes and the address and data buses. The width of each strobe and the idle gap after it are set by configuration inputs.

The device accepts bytes in page loads and programs each page as one operation. The controller therefore ends a load when the next address would leave the current 64-byte page, and also after the last byte. Once the device's byte-load window has passed, it reads back the last address written. It keeps reading until bit 7 shows the true value of the byte just written, and only then goes on. If the byte source stalls for longer than the window while a load is open, the device will already have begun programming. In that case the controller closes the load and polls at once. If the poll budget runs out, the controller reports a timeout and returns to idle. The strobe widths, the window length and the poll budget must be held steady while a transfer runs.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset the controller is idle: busy, s_ready, done and timeout are low, mem_ce_n, mem_we_n and mem_oe_n are high, and mem_dout_en is low.
- R2: Each byte is written with mem_we_n low for max(cfg_strobe_len,1) cycles. During that time mem_ce_n is low, mem_oe_n is high, mem_dout_en is high, and mem_addr and mem_dout stay unchanged.
- R3: A byte is taken when s_valid and s_ready are both high. The bytes are written in stream order to start_addr, start_addr+1, ..., with the address wrapping at 2^ADDR_W. s_ready is high only while busy.
- R4: No page load mixes addresses with different values of mem_addr[12:6]. Crossing from an address whose low 6 bits are all ones ends the load, and polling follows before the next byte is written.
- R5: When a load ends on a page boundary or on its final byte, mem_oe_n first falls cfg_gap_len+cfg_window_len cycles after mem_we_n rises for the last byte, with both taken as at least 1. Throughout that wait all strobes are high.
- R6: Each poll holds mem_ce_n and mem_oe_n low and mem_we_n high for max(cfg_strobe_len,1) cycles, on the address of the last byte written. mem_dout_en is low while mem_oe_n is low and in the cycle before it falls.
- R7: At the end of each poll, bit 7 of mem_din is compared with bit 7 of the last byte written. If they are equal, the page is complete. If not, another poll follows after max(cfg_gap_len,1) cycles.
- R8: Suppose at least one byte of the current load has been written and no byte is offered for max(cfg_window_len,1) cycles. The controller then stops accepting bytes, polls until the page completes, and only then writes the remaining bytes as a new load.
- R9: After max(cfg_poll_limit,1) failed polls of one load, timeout is high for one cycle and the controller returns to idle without raising done. A poll that matches counts as completion even when it is the last one allowed.
- R10: done is high for exactly one cycle after the final page completes, and in the cycle after a start with byte_count 0. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a transfer (sampled only while idle) |
| start_addr | input | ADDR_W | First byte address |
| byte_count | input | ADDR_W+1 | Number of bytes to write |
| s_valid | input | 1 | Stream byte offered |
| s_data | input | DATA_W | Stream byte |
| s_ready | output | 1 | Stream byte accepted when s_valid is also high |
| cfg_strobe_len | input | TIME_W | Write and read strobe low time in cycles (0 acts as 1) |
| cfg_gap_len | input | TIME_W | High time after each strobe in cycles (0 acts as 1) |
| cfg_window_len | input | TIME_W | Byte-load window budget in cycles (0 acts as 1) |
| cfg_poll_limit | input | TIME_W | Polls allowed per load (0 acts as 1) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse: transfer complete |
| timeout | output | 1 | One-cycle pulse: polling gave up |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dout | output | DATA_W | Data driven toward the memory |
| mem_dout_en | output | 1 | Enable for the data bus driver |
| mem_din | input | DATA_W | Data read from the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read strobe, active low |

## Verification
At the end of a poll, two outcomes can be due in the same cycle. The final poll allowed by the budget can also be the first one that returns the true bit 7, so completion and timeout fall together. The bench's memory model returns the complemented bit for a set number of polls. That number is first set to one less than the poll limit, so the match lands on the last permitted poll, and the run must end in done and not timeout. It is then set equal to the limit, and the run must end in timeout after exactly the limit's number of polls. A second contest comes from a stalled stream, where the window runs out while a load is open. There, the count of load closures and the scoreboard of written addresses show whether the load was closed and resumed at the right place.

// File: rtl/epw_pkg.sv
package epw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WE_LOW,
    ST_WE_HOLD,
    ST_SETTLE,
    ST_POLL_OE,
    ST_POLL_GAP
  } epw_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } epw_strobe_t;

endpackage

// File: rtl/epw_reset_sync.sv
module epw_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_int_n = sync_q[STAGES-1];

endmodule

// File: rtl/epw_span_timer.sv
module epw_span_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         last
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = (len == '0) ? W'(1) : len;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == W'(1));

endmodule

// File: rtl/epw_addr_track.sv
module epw_addr_track #(
  parameter int ADDR_W    = 13,
  parameter int PAGE_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [ADDR_W:0]   init_count,
  input  logic              advance,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] last_addr,
  output logic              last_in_page,
  output logic              final_byte,
  output logic              none_left
);

  localparam int CW = ADDR_W + 1;

  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [ADDR_W-1:0] prev_q, prev_d;
  logic [CW-1:0]     rem_q, rem_d;

  always_comb begin
    cur_d  = cur_q;
    prev_d = prev_q;
    rem_d  = rem_q;
    if (init) begin
      cur_d = init_addr;
      rem_d = init_count;
    end else if (advance) begin
      prev_d = cur_q;
      cur_d  = cur_q + 1'b1;
      rem_d  = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
      rem_q  <= '0;
    end else begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
      rem_q  <= rem_d;
    end
  end

  assign cur_addr     = cur_q;
  assign last_addr    = prev_q;
  assign last_in_page = &cur_q[PAGE_BITS-1:0];
  assign final_byte   = (rem_q == CW'(1));
  assign none_left    = (rem_q == '0);

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import epw_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int PAGE_BITS = 6,
  parameter int DATA_W    = 8,
  parameter int TIME_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W:0]   byte_count,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  input  logic [TIME_W-1:0] cfg_strobe_len,
  input  logic [TIME_W-1:0] cfg_gap_len,
  input  logic [TIME_W-1:0] cfg_window_len,
  input  logic [TIME_W-1:0] cfg_poll_limit,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);

  localparam int MSB = DATA_W - 1;

  logic rst_int_n;

  epw_state_e        state_q, state_d;
  logic [DATA_W-1:0] wr_data_q;
  logic              data_load;
  logic              loaded_q, loaded_d;
  logic [TIME_W-1:0] polls_q, polls_d;
  logic [TIME_W:0]   polls_next;
  logic [TIME_W:0]   limit_eff;
  logic              done_q, done_d;
  logic              tmo_q, tmo_d;

  logic              tmr_load;
  logic [TIME_W-1:0] tmr_len;
  logic              tmr_last;

  logic              trk_init, trk_adv;
  logic [ADDR_W-1:0] cur_addr, last_addr;
  logic              last_in_page, final_byte, none_left;

  logic              poll_match;
  logic              poll_side;
  epw_strobe_t       strb;
  logic              unused_din_bits;

  epw_reset_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  epw_span_timer #(.W(TIME_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (tmr_load),
    .len   (tmr_len),
    .last  (tmr_last)
  );

  epw_addr_track #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_trk (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .init         (trk_init),
    .init_addr    (start_addr),
    .init_count   (byte_count),
    .advance      (trk_adv),
    .cur_addr     (cur_addr),
    .last_addr    (last_addr),
    .last_in_page (last_in_page),
    .final_byte   (final_byte),
    .none_left    (none_left)
  );

  assign poll_match      = (mem_din[MSB] == wr_data_q[MSB]);
  assign unused_din_bits = ^mem_din[MSB-1:0];
  assign polls_next      = {1'b0, polls_q} + 1'b1;
  assign limit_eff       = (cfg_poll_limit == '0) ? (TIME_W+1)'(1) : {1'b0, cfg_poll_limit};

  // next-state logic
  always_comb begin
    state_d   = state_q;
    loaded_d  = loaded_q;
    polls_d   = polls_q;
    done_d    = 1'b0;
    tmo_d     = 1'b0;
    data_load = 1'b0;
    tmr_load  = 1'b0;
    tmr_len   = cfg_window_len;
    trk_init  = 1'b0;
    trk_adv   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          trk_init = 1'b1;
          if (byte_count == '0) begin
            done_d = 1'b1;
          end else begin
            state_d  = ST_FETCH;
            tmr_load = 1'b1;
            tmr_len  = cfg_window_len;
            loaded_d = 1'b0;
          end
        end
      end
      ST_FETCH: begin
        if (s_valid) begin
          data_load = 1'b1;
          state_d   = ST_WE_LOW;
          tmr_load  = 1'b1;
          tmr_len   = cfg_strobe_len;
        end else if (loaded_q && tmr_last) begin
          // source stalled past the load window: device is already programming
          state_d  = ST_POLL_OE;
          tmr_load = 1'b1;
          tmr_len  = cfg_strobe_len;
          loaded_d = 1'b0;
          polls_d  = '0;
        end
      end
      ST_WE_LOW: begin
        if (tmr_last) begin
          state_d  = ST_WE_HOLD;
          tmr_load = 1'b1;
          tmr_len  = cfg_gap_len;
        end
      end
      ST_WE_HOLD: begin
        if (tmr_last) begin
          trk_adv  = 1'b1;
          loaded_d = 1'b1;
          tmr_load = 1'b1;
          tmr_len  = cfg_window_len;
          if (final_byte || last_in_page) state_d = ST_SETTLE;
          else                            state_d = ST_FETCH;
        end
      end
      ST_SETTLE: begin
        if (tmr_last) begin
          state_d  = ST_POLL_OE;
          tmr_load = 1'b1;
          tmr_len  = cfg_strobe_len;
          loaded_d = 1'b0;
          polls_d  = '0;
        end
      end
      ST_POLL_OE: begin
        if (tmr_last) begin
          if (poll_match) begin
            if (none_left) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end else begin
              state_d  = ST_FETCH;
              tmr_load = 1'b1;
              tmr_len  = cfg_window_len;
            end
          end else if (polls_next >= limit_eff) begin
            state_d = ST_IDLE;
            tmo_d   = 1'b1;
          end else begin
            polls_d  = polls_next[TIME_W-1:0];
            state_d  = ST_POLL_GAP;
            tmr_load = 1'b1;
            tmr_len  = cfg_gap_len;
          end
        end
      end
      ST_POLL_GAP: begin
        if (tmr_last) begin
          state_d  = ST_POLL_OE;
          tmr_load = 1'b1;
          tmr_len  = cfg_strobe_len;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q   <= ST_IDLE;
      loaded_q  <= 1'b0;
      polls_q   <= '0;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      wr_data_q <= '0;
    end else begin
      state_q  <= state_d;
      loaded_q <= loaded_d;
      polls_q  <= polls_d;
      done_q   <= done_d;
      tmo_q    <= tmo_d;
      if (data_load) wr_data_q <= s_data;
    end
  end

  // strobe decode
  always_comb begin
    strb = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    case (state_q)
      ST_WE_LOW:  strb = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
      ST_WE_HOLD: strb = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1};
      ST_POLL_OE: strb = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
      default:    strb = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    endcase
  end

  assign poll_side   = (state_q == ST_SETTLE) || (state_q == ST_POLL_OE) ||
                       (state_q == ST_POLL_GAP);
  assign mem_addr    = poll_side ? last_addr : cur_addr;
  assign mem_dout    = wr_data_q;
  assign mem_dout_en = strb.drive;
  assign mem_ce_n    = strb.ce_n;
  assign mem_we_n    = strb.we_n;
  assign mem_oe_n    = strb.oe_n;
  assign s_ready     = (state_q == ST_FETCH);
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign timeout     = tmo_q;

endmodule

// File: rtl/epw_checker.sv
module epw_checker #(
  parameter int ADDR_W    = 13,
  parameter int PAGE_BITS = 6,
  parameter int DATA_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              s_ready,
  input logic              done,
  input logic              timeout,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dout,
  input logic              mem_dout_en,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n
);

  localparam int PG_W = ADDR_W - PAGE_BITS;

  logic            open_q;
  logic [PG_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      page_q <= '0;
    end else begin
      if (!mem_we_n) begin
        open_q <= 1'b1;
        page_q <= mem_addr[ADDR_W-1:PAGE_BITS];
      end else if (!mem_oe_n) begin
        open_q <= 1'b0;
      end
    end
  end

  assert_we_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dout_en));

  assert_we_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

  assert_ready_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> busy);

  assert_one_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && open_q) |-> (mem_addr[ADDR_W-1:PAGE_BITS] == page_q));

  assert_read_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dout_en));

  assert_release_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dout_en));

  assert_not_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind eeprom_page_writer epw_checker #(
  .ADDR_W    (ADDR_W),
  .PAGE_BITS (PAGE_BITS),
  .DATA_W    (DATA_W)
) u_epw_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .s_ready     (s_ready),
  .done        (done),
  .timeout     (timeout),
  .mem_addr    (mem_addr),
  .mem_dout    (mem_dout),
  .mem_dout_en (mem_dout_en),
  .mem_ce_n    (mem_ce_n),
  .mem_we_n    (mem_we_n),
  .mem_oe_n    (mem_oe_n)
);

// File: tb/tb_eeprom_page_writer.sv
`timescale 1ns/1ps
module tb_eeprom_page_writer;

  localparam int AW = 13;
  localparam int DW = 8;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] start_addr;
  logic [AW:0]   byte_count;
  logic          s_valid;
  logic [DW-1:0] s_data;
  logic          s_ready;
  logic [TW-1:0] cfg_strobe_len, cfg_gap_len, cfg_window_len, cfg_poll_limit;
  logic          busy, done, timeout;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dout;
  logic          mem_dout_en;
  logic [DW-1:0] mem_din;
  logic          mem_ce_n, mem_we_n, mem_oe_n;

  always #2.5 clk = ~clk;

  eeprom_page_writer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .cfg_strobe_len(cfg_strobe_len), .cfg_gap_len(cfg_gap_len),
    .cfg_window_len(cfg_window_len), .cfg_poll_limit(cfg_poll_limit),
    .busy(busy), .done(done), .timeout(timeout), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  int total = 0;
  int bad = 0;

  // memory model: answers polls with the complement for busy_polls reads
  logic [DW-1:0] md = '0;
  logic [AW-1:0] last_wr_addr = '0;
  int polls_seen = 0;
  int busy_polls = 0;
  assign mem_din = (!mem_oe_n && !mem_ce_n) ?
                   ((polls_seen <= busy_polls) ? {~md[DW-1], md[DW-2:0]} : md) : '0;

  logic [AW+DW-1:0] exp_q[$];

  int writes = 0, polls = 0, loads_closed = 0, done_cnt = 0, tmo_cnt = 0;
  int settle_meas = 0, since_rise = 0, we_len = 0, oe_len = 0;
  int exp_strobe = 1;
  bit after_write = 0;
  bit prev_we = 1, prev_oe = 1, prev_done = 0;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_data;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      since_rise++;
      if (!mem_we_n) begin
        we_len++;
        cap_addr = mem_addr;
        cap_data = mem_dout;
      end
      if (mem_we_n && !prev_we) begin
        logic [AW+DW-1:0] e;
        writes++;
        chk(we_len == exp_strobe, "R2", "write strobe width", we_len, exp_strobe);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected write addr", int'(cap_addr), -1);
        end else begin
          e = exp_q.pop_front();
          chk(cap_addr == e[AW+DW-1:DW], "R3", "write address", int'(cap_addr), int'(e[AW+DW-1:DW]));
          chk(cap_data == e[DW-1:0], "R3", "write data", int'(cap_data), int'(e[DW-1:0]));
        end
        md = cap_data;
        last_wr_addr = cap_addr;
        polls_seen = 0;
        since_rise = 0;
        after_write = 1;
        we_len = 0;
      end
      if (!mem_oe_n && prev_oe) begin
        polls++;
        polls_seen++;
        if (after_write) begin
          settle_meas = since_rise;
          loads_closed++;
          after_write = 0;
        end
        chk(mem_addr == last_wr_addr, "R6", "poll address", int'(mem_addr), int'(last_wr_addr));
      end
      if (!mem_oe_n) oe_len++;
      if (mem_oe_n && !prev_oe) begin
        chk(oe_len == exp_strobe, "R6", "read strobe width", oe_len, exp_strobe);
        oe_len = 0;
      end
      if (done) done_cnt++;
      if (timeout) tmo_cnt++;
      if (done && prev_done) chk(1'b0, "R10", "done longer than one cycle", 2, 1);
      prev_we = mem_we_n;
      prev_oe = mem_oe_n;
      prev_done = done;
    end
  end

  task automatic push_byte(input logic [DW-1:0] d);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = d;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic set_cfg(input int stb, input int gap, input int win, input int lim);
    cfg_strobe_len = TW'(stb);
    cfg_gap_len    = TW'(gap);
    cfg_window_len = TW'(win);
    cfg_poll_limit = TW'(lim);
    exp_strobe     = (stb == 0) ? 1 : stb;
  endtask

  // driver: queues expected writes, starts, streams, waits for done or timeout
  task automatic run_xfer(input int addr, input int cnt, input int base,
                          input int stall_at, input int stall_len, input bit poke);
    int d0, t0;
    for (int i = 0; i < cnt; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] v;
      a = AW'(addr + i);
      v = DW'(base + i * 7);
      exp_q.push_back({a, v});
    end
    d0 = done_cnt;
    t0 = tmo_cnt;
    @(negedge clk);
    start_addr = AW'(addr);
    byte_count = (AW+1)'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < cnt; i++) begin
      if (i == stall_at) repeat (stall_len) @(negedge clk);
      push_byte(DW'(base + i * 7));
      if (poke && i == 0) begin
        start_addr = AW'(13'h0700);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    while (done_cnt == d0 && tmo_cnt == t0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0, p0, l0, d0, t0;
    rst_n = 1'b0;
    start = 1'b0;
    start_addr = '0;
    byte_count = '0;
    s_valid = 1'b0;
    s_data = '0;
    set_cfg(2, 1, 6, 20);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(busy == 0 && s_ready == 0, "R1", "busy/ready after reset", int'({busy, s_ready}), 0);
    chk(done == 0 && timeout == 0, "R1", "done/timeout after reset", int'({done, timeout}), 0);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dout_en, "R1", "strobes after reset",
        int'({mem_ce_n, mem_we_n, mem_oe_n, mem_dout_en}), 14);

    // A: three bytes in one page, two busy polls
    busy_polls = 2;
    w0 = writes; p0 = polls; l0 = loads_closed; d0 = done_cnt; t0 = tmo_cnt;
    run_xfer(13'h005, 3, 8'h81, -1, 0, 0);
    chk(writes - w0 == 3, "R3", "bytes written", writes - w0, 3);
    chk(polls - p0 == 3, "R7", "polls until match", polls - p0, 3);
    chk(settle_meas == 7, "R5", "write-to-poll wait", settle_meas, 7);
    chk(done_cnt - d0 == 1 && tmo_cnt == t0, "R10", "done once", done_cnt - d0, 1);
    chk(busy == 0, "R10", "idle after done", int'(busy), 0);

    // B: crosses a page boundary, strobe 0 acts as 1
    set_cfg(0, 2, 5, 20);
    busy_polls = 0;
    w0 = writes; p0 = polls; l0 = loads_closed; d0 = done_cnt;
    run_xfer(13'h03E, 4, 8'h10, -1, 0, 0);
    chk(writes - w0 == 4, "R3", "bytes across boundary", writes - w0, 4);
    chk(loads_closed - l0 == 2, "R4", "loads split at page end", loads_closed - l0, 2);
    chk(polls - p0 == 2, "R7", "one poll per load", polls - p0, 2);
    chk(settle_meas == 7, "R5", "wait with gap 2 window 5", settle_meas, 7);
    chk(done_cnt - d0 == 1, "R10", "done after split", done_cnt - d0, 1);

    // C: stream stall closes an open load
    set_cfg(2, 1, 6, 20);
    busy_polls = 1;
    w0 = writes; p0 = polls; l0 = loads_closed; d0 = done_cnt;
    run_xfer(13'h100, 3, 8'h3C, 1, 20, 0);
    chk(writes - w0 == 3, "R8", "bytes after stall", writes - w0, 3);
    chk(loads_closed - l0 == 2, "R8", "load closed on stall", loads_closed - l0, 2);
    chk(polls - p0 == 4, "R8", "polls for two loads", polls - p0, 4);
    chk(done_cnt - d0 == 1, "R8", "done after stall", done_cnt - d0, 1);

    // D: match on the last allowed poll wins over timeout
    set_cfg(1, 1, 4, 3);
    busy_polls = 2;
    p0 = polls; d0 = done_cnt; t0 = tmo_cnt;
    run_xfer(13'h1FF0, 2, 8'h7E, -1, 0, 0);
    chk(polls - p0 == 3, "R9", "polls with match on last", polls - p0, 3);
    chk(done_cnt - d0 == 1 && tmo_cnt == t0, "R9", "match beats timeout", tmo_cnt - t0, 0);

    // E: budget exhausted
    busy_polls = 3;
    p0 = polls; d0 = done_cnt; t0 = tmo_cnt;
    run_xfer(13'h1FF4, 2, 8'h05, -1, 0, 0);
    chk(polls - p0 == 3, "R9", "polls before timeout", polls - p0, 3);
    chk(tmo_cnt - t0 == 1 && done_cnt == d0, "R9", "timeout without done", tmo_cnt - t0, 1);
    chk(busy == 0, "R9", "idle after timeout", int'(busy), 0);

    // F: poll limit 0 acts as 1
    set_cfg(1, 1, 4, 0);
    busy_polls = 1000;
    p0 = polls; t0 = tmo_cnt;
    run_xfer(13'h0A0, 1, 8'hF0, -1, 0, 0);
    chk(polls - p0 == 1 && tmo_cnt - t0 == 1, "R9", "limit zero", polls - p0, 1);

    // G: zero byte count
    set_cfg(2, 1, 6, 20);
    busy_polls = 0;
    w0 = writes; d0 = done_cnt;
    run_xfer(13'h050, 0, 0, -1, 0, 0);
    chk(done_cnt - d0 == 1 && writes == w0, "R10", "zero count done", done_cnt - d0, 1);

    // H: start while busy is ignored
    w0 = writes; d0 = done_cnt;
    run_xfer(13'h020, 2, 8'h44, -1, 0, 1);
    chk(writes - w0 == 2, "R10", "start while busy ignored", writes - w0, 2);
    chk(done_cnt - d0 == 1, "R10", "single done", done_cnt - d0, 1);

    chk(exp_q.size() == 0, "R3", "expected writes left", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule